// File: doc/BRIEF.md
# First-Last Anchor Substring Search Engine

This engine looks for a needle of programmable length k (2 to 16 bytes) inside a haystack of n bytes. The haystack arrives as a stream of 8-byte chunks. Software first writes the needle bytes into a small register file, one byte per address. It then sets the two lengths and pulses `start`. The engine finishes with a one-cycle `done` pulse, a `found` flag and the index of the earliest occurrence.

For each chunk the engine tests all eight positions in parallel with a cheap two-byte predicate. A position p is a candidate when haystack byte p equals needle byte 0 and haystack byte p+a equals needle byte a. The second anchor a is the highest needle index whose byte differs from byte 0. When every needle byte is the same, the engine switches to an all-same mode that anchors on the last byte, k−1. Candidates are confirmed one at a time, lowest position first. Confirmation compares one byte per cycle against a local window of three chunks and skips the two anchor bytes. Candidates that would run past the end of the haystack are masked off.

Top module: `pair_anchor_search`

## Requirements
- R1: After reset `done`, `found`, `match_idx` and `chunk_ready` are all 0.
- R2: Haystack byte index 8c+b travels in chunk c at bits [8b+7:8b], and chunks are taken on cycles where `chunk_valid` and `chunk_ready` are both high. The engine never takes more than ceil(n/8) chunks in one search.
- R3: Position p is a candidate only when byte p equals needle byte 0 and byte p+a equals needle byte a. Here a is the largest index below k whose needle byte differs from byte 0. A needle whose bytes are all equal uses a = k−1.
- R4: When several occurrences exist, `match_idx` reports the lowest index.
- R5: Occurrences that straddle a chunk boundary are found, for every k from 2 to 16, including k = 16.
- R6: A position p with p + k > n never matches, even if bytes past the end of the haystack would complete the needle.
- R7: When n < k, the search ends with `found` = 0.
- R8: `done` lasts exactly one cycle. `found` and `match_idx` change only in the cycle in which `done` is high, and hold their values between searches.
- R9: A `start` pulse while a search is running is ignored, and the running search still returns its own result.
- R10: The needle byte at address i is written through `ndl_we`/`ndl_addr`/`ndl_data`. `ndl_len` and `hay_len` are sampled on `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ndl_we | input | 1 | Needle byte write enable |
| ndl_addr | input | 4 | Needle byte address |
| ndl_data | input | 8 | Needle byte value |
| ndl_len | input | 5 | Needle length k, sampled on start |
| hay_len | input | 16 | Haystack length n, sampled on start |
| start | input | 1 | Begin a search (accepted only when idle) |
| chunk_valid | input | 1 | Haystack chunk present |
| chunk_data | input | 64 | Haystack chunk, lowest byte index in bits [7:0] |
| chunk_ready | output | 1 | Engine takes the chunk this cycle |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Occurrence found in the last search |
| match_idx | output | 16 | Index of the earliest occurrence |

## Verification
The bench aims at the places where a two-byte filter goes wrong:
- A needle whose first and last bytes are equal, buried in a run of that byte. A design that anchored on the last byte instead of the farthest differing one would still answer correctly, but a design that skipped the wrong byte during confirmation would report a false match.
- A needle that straddles a chunk boundary, and k = 16. A window that is too narrow, or shifted wrongly, would lose these matches.
- A haystack padded with bytes that would complete the needle just past n. A missing end mask would report an index beyond the data.
- Several occurrences in one chunk. Picking candidates in the wrong order would report a later index.
- A stray start in the middle of a search. A design that restarts on it would return the wrong answer.

// File: rtl/pair_anchor_search.sv
module pair_anchor_search #(
  parameter int CW   = 8,
  parameter int MAXK = 16,
  parameter int IW   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ndl_we,
  input  logic [$clog2(MAXK)-1:0]   ndl_addr,
  input  logic [7:0]                ndl_data,
  input  logic [$clog2(MAXK+1)-1:0] ndl_len,
  input  logic [IW-1:0]             hay_len,
  input  logic                      start,
  input  logic                      chunk_valid,
  input  logic [CW*8-1:0]           chunk_data,
  output logic                      chunk_ready,
  output logic                      done,
  output logic                      found,
  output logic [IW-1:0]             match_idx
);
  localparam int AW    = $clog2(MAXK);
  localparam int KW    = $clog2(MAXK+1);
  localparam int SLOTS = (2*CW + MAXK - 2) / CW;
  localparam int NB    = SLOTS * CW;
  localparam int PW    = $clog2(CW);
  localparam int SW    = $clog2(SLOTS+1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SCAN, S_CHECK, S_FIN} st_t;
  st_t state;

  logic [7:0]      ndl [MAXK];
  logic [NB*8-1:0] win;
  logic [KW-1:0]   klen, j;
  logic [AW-1:0]   aoff, far;
  logic [IW-1:0]   nlen, fetched, total, hidx, idx_q;
  logic [IW:0]     base;
  logic [SW-1:0]   have;
  logic [CW-1:0]   cmask, cand;
  logic [PW-1:0]   pos;
  logic [7:0]      vbyte;
  logic            hit, found_q, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < MAXK; t++) ndl[t] <= '0;
    end else if (ndl_we) begin
      ndl[ndl_addr] <= ndl_data;
    end
  end

  // farthest needle byte differing from byte 0, else k-1 (all-same mode)
  always_comb begin
    far = AW'(ndl_len - 1'b1);
    for (int t = 1; t < MAXK; t++)
      if (KW'(t) < ndl_len && ndl[t] != ndl[0]) far = AW'(t);
  end

  for (genvar p = 0; p < CW; p++) begin : g_cand
    assign cand[p] = (win[p*8 +: 8] == ndl[0]) &&
                     (win[(p + int'(aoff))*8 +: 8] == ndl[aoff]) &&
                     (int'(base) + p + int'(klen) <= int'(nlen));
  end

  always_comb begin
    pos = '0;
    for (int p = CW-1; p >= 0; p--)
      if (cmask[p]) pos = PW'(p);
  end

  assign vbyte       = win[(int'(pos) + int'(j))*8 +: 8];
  assign chunk_ready = (state == S_LOAD) && (have != SW'(SLOTS)) && (fetched != total);
  assign done        = done_q;
  assign found       = found_q;
  assign match_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      win     <= '0;
      klen    <= '0;
      j       <= '0;
      aoff    <= '0;
      nlen    <= '0;
      fetched <= '0;
      total   <= '0;
      hidx    <= '0;
      idx_q   <= '0;
      base    <= '0;
      have    <= '0;
      cmask   <= '0;
      hit     <= 1'b0;
      found_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          klen    <= ndl_len;
          nlen    <= hay_len;
          aoff    <= far;
          base    <= '0;
          fetched <= '0;
          have    <= '0;
          win     <= '0;
          hit     <= 1'b0;
          total   <= IW'(({1'b0, hay_len} + (IW+1)'(CW-1)) / (IW+1)'(CW));
          state   <= (hay_len < IW'(ndl_len)) ? S_FIN : S_LOAD;
        end
        S_LOAD: begin
          if (have == SW'(SLOTS) || fetched == total) begin
            state <= S_SCAN;
          end else if (chunk_valid) begin
            win[int'(have)*CW*8 +: CW*8] <= chunk_data;
            have    <= have + 1'b1;
            fetched <= fetched + 1'b1;
          end
        end
        S_SCAN: begin
          cmask <= cand;
          j     <= KW'(1);
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (cmask == '0) begin
            if (int'(base) + CW + int'(klen) > int'(nlen)) begin
              state <= S_FIN;
            end else begin
              base  <= base + (IW+1)'(CW);
              win   <= {{(CW*8){1'b0}}, win[NB*8-1:CW*8]};
              have  <= have - 1'b1;
              state <= S_LOAD;
            end
          end else if (j >= klen) begin
            hit   <= 1'b1;
            hidx  <= IW'(base) + IW'(pos);
            state <= S_FIN;
          end else if (j == KW'(aoff) || vbyte == ndl[j[AW-1:0]]) begin
            j <= j + 1'b1;
          end else begin
            cmask[pos] <= 1'b0;
            j          <= KW'(1);
          end
        end
        S_FIN: begin
          done_q  <= 1'b1;
          found_q <= hit;
          idx_q   <= hit ? hidx : '0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found) && $stable(match_idx)));

  // R6
  match_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (int'(match_idx) + int'(klen) <= int'(nlen)));

  // R2
  fetch_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetched <= total);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && start) |=> ($stable(nlen) && $stable(klen)));

  // R3
  cand_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && cmask != '0) |-> (win[int'(pos)*8 +: 8] == ndl[0]));
endmodule

// File: tb/test_pair_anchor_search.sv
`timescale 1ns/1ps
module test_pair_anchor_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ndl_we = 1'b0;
  logic [3:0]  ndl_addr = '0;
  logic [7:0]  ndl_data = '0;
  logic [4:0]  ndl_len = 5'd2;
  logic [15:0] hay_len = '0;
  logic        start = 1'b0;
  logic        chunk_valid = 1'b0;
  logic [63:0] chunk_data = '0;
  logic        chunk_ready, done, found;
  logic [15:0] match_idx;

  pair_anchor_search i_pair_anchor_search (
    .clk(clk), .rst_n(rst_n), .ndl_we(ndl_we), .ndl_addr(ndl_addr),
    .ndl_data(ndl_data), .ndl_len(ndl_len), .hay_len(hay_len), .start(start),
    .chunk_valid(chunk_valid), .chunk_data(chunk_data), .chunk_ready(chunk_ready),
    .done(done), .found(found), .match_idx(match_idx));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int cidx = 0, ctot = 0;
  bit hs_pend = 1'b0, finished = 1'b0;
  logic [7:0] hay [0:511];
  logic [7:0] nd [0:15];

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // chunk source: lowest byte index in bits [7:0] (R2)
  always @(negedge clk) begin
    if (hs_pend) cidx++;
    chunk_valid = (cidx < ctot);
    for (int b = 0; b < 8; b++) chunk_data[b*8 +: 8] = hay[(cidx*8 + b) & 511];
    hs_pend = chunk_valid && chunk_ready;
  end

  // per-clock reference comparison of held outputs and chunk count
  logic pf = 1'b0, pd = 1'b0;
  logic [15:0] pi = '0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (!done) chk(found === pf && match_idx === pi, "R8 hold", int'(match_idx), int'(pi));
      else chk(!pd, "R8 pulse", int'(pd), 0);
      chk(cidx <= ctot, "R2 chunk count", cidx, ctot);
    end
    pf = found; pi = match_idx; pd = done;
  end

  function automatic int ref_find(int n, int k);
    for (int i = 0; i + k <= n; i++) begin
      bit ok = 1'b1;
      for (int t = 0; t < k; t++) if (hay[i+t] != nd[t]) ok = 1'b0;
      if (ok) return i;
    end
    return -1;
  endfunction

  task automatic set_hay(string s);
    for (int i = 0; i < 512; i++) hay[i] = 8'h2e;
    for (int i = 0; i < s.len(); i++) hay[i] = s[i];
  endtask

  task automatic load_needle(string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk); #1;
      ndl_we = 1'b1; ndl_addr = 4'(i); ndl_data = s[i]; nd[i] = s[i];
    end
    @(negedge clk); #1;
    ndl_we = 1'b0;
  endtask

  task automatic run(string req, int n, int k, int poke);
    int exp, t;
    exp = ref_find(n, k);
    @(negedge clk); #1;
    hay_len = 16'(n); ndl_len = 5'(k); ctot = (n + 7) / 8; cidx = 0; hs_pend = 1'b0;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    t = 0;
    while (!done && t < 4000) begin
      if (poke > 0 && t == poke) begin
        hay_len = 16'd3; ndl_len = 5'd2; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0; hay_len = 16'(n); ndl_len = 5'(k);
        t++;
      end else begin
        @(negedge clk); #1;
        t++;
      end
    end
    chk(done === 1'b1, {req, " done"}, int'(done), 1);
    chk(found === (exp >= 0), {req, " found"}, int'(found), int'(exp >= 0));
    if (exp >= 0) chk(int'(match_idx) == exp, {req, " index"}, int'(match_idx), exp);
    @(negedge clk); #1;
    chk(done === 1'b0, "R8 single-cycle done", int'(done), 0);
  endtask

  initial begin
    set_hay("");
    for (int i = 0; i < 16; i++) nd[i] = '0;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && found === 1'b0, "R1 reset outputs", int'(found), 0);
    chk(match_idx === 16'd0 && chunk_ready === 1'b0, "R1 reset idx/ready", int'(match_idx), 0);
    #1 rst_n = 1'b1;

    // R3 R10 worked case
    load_needle("cat"); set_hay("a_cat_tries");
    run("R3", 11, 3, 0);
    // R7 / plain miss
    set_hay("a_dog_tries"); run("R3 miss", 11, 3, 0);
    load_needle("cattle"); set_hay("cat"); run("R7", 3, 6, 0);
    // R4 earliest of several
    load_needle("ab"); set_hay("xabyabzab_ab"); run("R4", 12, 2, 0);
    // R6 needle completed only beyond n
    set_hay("xxxxab"); run("R6", 5, 2, 0);
    // R5 boundary straddle
    load_needle("hello"); set_hay("zzzzzzhellozzzzz"); run("R5 straddle", 16, 5, 0);
    // R5 k=16 later chunk
    load_needle("0123456789abcdef");
    set_hay("----------------------0123456789abcdef--");
    run("R5 k16", 40, 16, 0);
    // R3 farthest differing anchor
    load_needle("AjohndoeA");
    set_hay("AAAAAAAAAAAAAAAAAjohndoeAAAAAAA");
    run("R3 far anchor", 31, 9, 0);
    set_hay("AAAAAAAAAAAAAjohnXoeAAAAAAAAAA"); run("R3 far miss", 30, 9, 0);
    // R3 all-same mode
    load_needle("aaaa"); set_hay("aaabaaabaaaaab"); run("R3 all-same", 14, 4, 0);
    // R6 last legal position k=2
    load_needle("qz"); set_hay("............qz"); run("R6 last pos", 14, 2, 0);
    // R9 stray start mid-search
    load_needle("wxyz");
    set_hay("");
    hay[180] = "w"; hay[181] = "x"; hay[182] = "y"; hay[183] = "z";
    run("R9", 200, 4, 12);
    // random small-alphabet searches
    for (int r = 0; r < 24; r++) begin
      string ns = "";
      int k = 2 + int'($urandom % 5);
      int n = int'($urandom % 60);
      for (int i = 0; i < k; i++) ns = {ns, (($urandom % 2) != 0) ? "a" : "b"};
      load_needle(ns);
      for (int i = 0; i < 512; i++) hay[i] = (($urandom % 2) != 0) ? 8'h61 : 8'h62;
      run("R4 random", n, k, 0);
    end
    finish_run();
  end
endmodule